// File: doc/BRIEF.md
# Sign-First Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a converter that returns a 12-bit magnitude plus a sign. A host starts a conversion with a write strobe, in the way it would write to a memory location. The sequencer first settles the polarity of the differential input. If the input is negative, it reverses the sampling polarity. The magnitude search that follows therefore always sees a positive quantity and needs only a unipolar DAC.

The search tries 12 bits, most significant first, against a one-bit comparator. Each trial lasts one step of a clock divided by eight: a four-cycle sample half followed by a four-cycle compare half. After the last trial a completion flag is set. An update phase of two cycles follows. Its first cycle writes the 13-bit two's-complement word into the output latch and clears the internal search state. Its second cycle raises end-of-conversion and drops the active-low interrupt. A host that reacts to either signal always finds valid data and a sequencer ready for the next start. The DAC and the comparator are analog parts outside this block.

Top module: `sgn_sar_seq`

## Requirements
- R1: After reset, busy, conv_done and eoc are 0, int_n is 1, dac_code is 0, swap_pol is 0 and result is 0.
- R2: A start is accepted on the clock edge that first sees wr_n low after a high, with cs_n low and stat_n high. Busy is then 1 and int_n is 1. A falling wr_n while cs_n is high has no effect.
- R3: For the first 8 cycles of a conversion, the sign step, dac_code is 0 and swap_pol is 0. From the end of that step, swap_pol is 1 exactly when the comparator reported cmp_hi = 0 (input below zero), and it stays so for all magnitude trials.
- R4: The 12 magnitude trials run from bit 11 down to bit 0. Each trial shows its bit set on dac_code, together with the bits already kept, and keeps the bit only if cmp_hi is 1 at the end of the trial. The first trial shows dac_code = 12'h800.
- R5: Each step lasts 8 cycles. samp_b is 0 in the first 4 cycles and 1 in the last 4 cycles of every step.
- R6: Counting the start edge as edge 0, conv_done becomes 1 after edge 104 while eoc is still 0. eoc becomes 1 after edge 106.
- R7: After edge 105, result already holds the new word, busy is 0, dac_code is 0, swap_pol is 0 and eoc is still 0. eoc rises and int_n falls together one cycle later.
- R8: result is the magnitude zero-extended to 13 bits when the sign is 0, and its 13-bit two's complement when the sign is 1. A negative sign with magnitude 0 gives 0.
- R9: A new start while a conversion runs restarts the sequence from the sign step. Only the new conversion delivers a result.
- R10: A status write (cs_n, wr_n and stat_n all low at a clock edge) clears busy, conv_done, eoc and swap_pol and sets int_n to 1 after that edge. It aborts a running conversion, so no eoc follows, and it leaves result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; its falling edge starts a conversion |
| stat_n | input | 1 | Status select, active low; low with a write aborts and clears |
| cmp_hi | input | 1 | Comparator: 1 when the sampled input is at or above the DAC level |
| dac_code | output | 12 | Code driven to the magnitude DAC |
| swap_pol | output | 1 | Reverses the input sampling polarity |
| samp_b | output | 1 | High in the second (compare) half of each step |
| result | output | 13 | Latched two's-complement result |
| busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | Last bit trial has finished |
| eoc | output | 1 | End of conversion, raised after the update phase |
| int_n | output | 1 | Interrupt, active low, drops when the latch holds new data |

## Verification
The hardest case to reach is a negative sign with a magnitude of zero. A comparator that behaves honestly never reports negative for a zero input. The bench comparator model therefore has an override that answers "below" only while dac_code is 0 and swap_pol is 0, which happens only in the sign step. The later trials then search a zero magnitude. The other difficult cases are a restart and an abort in the middle of the search. These are placed at a fixed cycle count after the start edge, so they fall well inside the trial sequence.

// File: rtl/sgn_sar_pkg.sv
package sgn_sar_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SIGN,
        ST_TRIAL,
        ST_UPD_LATCH,
        ST_UPD_FLAG
    } seq_st_e;
endpackage

// File: rtl/sgn_sar_strobe.sv
// Bus strobe decode: start on falling write, abort on status write.
module sgn_sar_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic stat_n,
    output logic start,
    output logic abort
);
    logic wr_d, wr_q;

    always_comb begin
        wr_d  = wr_n;
        abort = !cs_n && !wr_n && !stat_n;
        start = wr_q && !wr_n && !cs_n && stat_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_d;
    end
endmodule

// File: rtl/sgn_sar_phase.sv
// Step timer: divides the clock by 2**DIV_LOG.
module sgn_sar_phase #(
    parameter int DIV_LOG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic ph_last,
    output logic second_half
);
    logic [DIV_LOG-1:0] ph_d, ph_q;

    always_comb begin
        if (clr)      ph_d = '0;
        else if (run) ph_d = ph_q + 1'b1;
        else          ph_d = '0;
        ph_last     = run && (ph_q == {DIV_LOG{1'b1}});
        second_half = run && ph_q[DIV_LOG-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/sgn_sar_fmt.sv
// Sign and magnitude to two's complement.
module sgn_sar_fmt #(
    parameter int MAG_W = 12
) (
    input  logic             neg,
    input  logic [MAG_W-1:0] mag,
    output logic [MAG_W:0]   word
);
    logic [MAG_W:0] ext;

    always_comb begin
        ext  = {1'b0, mag};
        word = neg ? (~ext + 1'b1) : ext;
    end
endmodule

// File: rtl/sgn_sar_seq.sv
module sgn_sar_seq
    import sgn_sar_pkg::*;
#(
    parameter int MAG_W   = 12,
    parameter int DIV_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             stat_n,
    input  logic             cmp_hi,
    output logic [MAG_W-1:0] dac_code,
    output logic             swap_pol,
    output logic             samp_b,
    output logic [MAG_W:0]   result,
    output logic             busy,
    output logic             conv_done,
    output logic             eoc,
    output logic             int_n
);
    localparam int IDX_W = $clog2(MAG_W);
    localparam logic [MAG_W-1:0] LSB_ONE = {{(MAG_W-1){1'b0}}, 1'b1};
    localparam logic [MAG_W-1:0] TOP_BIT = LSB_ONE << (MAG_W - 1);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAG_W - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [MAG_W-1:0] code;
        logic [IDX_W-1:0] idx;
        logic             sign;
        logic             swap;
        logic             busy;
        logic             cc;
        logic             eoc;
        logic             int_n;
        logic [MAG_W:0]   res;
    } seq_t;

    seq_t s_d, s_q;
    logic start, abort, ph_last, second_half, running;
    logic [MAG_W-1:0] cur_bit, kept;
    logic [MAG_W:0]   fmt_word;

    sgn_sar_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .wr_n  (wr_n),
        .stat_n(stat_n),
        .start (start),
        .abort (abort)
    );

    assign running = (s_q.st == ST_SIGN) || (s_q.st == ST_TRIAL);

    sgn_sar_phase #(.DIV_LOG(DIV_LOG)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start || abort),
        .run        (running),
        .ph_last    (ph_last),
        .second_half(second_half)
    );

    sgn_sar_fmt #(.MAG_W(MAG_W)) u_fmt (
        .neg (s_q.sign),
        .mag (s_q.code),
        .word(fmt_word)
    );

    always_comb begin
        s_d     = s_q;
        cur_bit = LSB_ONE << s_q.idx;
        kept    = cmp_hi ? s_q.code : (s_q.code & ~cur_bit);
        if (abort) begin
            s_d.st    = ST_IDLE;
            s_d.code  = '0;
            s_d.idx   = '0;
            s_d.sign  = 1'b0;
            s_d.swap  = 1'b0;
            s_d.busy  = 1'b0;
            s_d.cc    = 1'b0;
            s_d.eoc   = 1'b0;
            s_d.int_n = 1'b1;
        end else if (start) begin
            s_d.st    = ST_SIGN;
            s_d.code  = '0;
            s_d.idx   = '0;
            s_d.sign  = 1'b0;
            s_d.swap  = 1'b0;
            s_d.busy  = 1'b1;
            s_d.cc    = 1'b0;
            s_d.eoc   = 1'b0;
            s_d.int_n = 1'b1;
        end else begin
            unique case (s_q.st)
                ST_SIGN: if (ph_last) begin
                    s_d.sign = !cmp_hi;
                    s_d.swap = !cmp_hi;
                    s_d.idx  = TOP_IDX;
                    s_d.code = TOP_BIT;
                    s_d.st   = ST_TRIAL;
                end
                ST_TRIAL: if (ph_last) begin
                    if (s_q.idx == '0) begin
                        s_d.code = kept;
                        s_d.cc   = 1'b1;
                        s_d.st   = ST_UPD_LATCH;
                    end else begin
                        s_d.idx  = s_q.idx - 1'b1;
                        s_d.code = kept | (cur_bit >> 1);
                    end
                end
                ST_UPD_LATCH: begin
                    s_d.res  = fmt_word;
                    s_d.code = '0;
                    s_d.idx  = '0;
                    s_d.swap = 1'b0;
                    s_d.busy = 1'b0;
                    s_d.st   = ST_UPD_FLAG;
                end
                ST_UPD_FLAG: begin
                    s_d.eoc   = 1'b1;
                    s_d.int_n = 1'b0;
                    s_d.st    = ST_IDLE;
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.int_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_code  = s_q.code;
    assign swap_pol  = s_q.swap;
    assign samp_b    = second_half;
    assign result    = s_q.res;
    assign busy      = s_q.busy;
    assign conv_done = s_q.cc;
    assign eoc       = s_q.eoc;
    assign int_n     = s_q.int_n;
endmodule

// File: rtl/sgn_sar_chk.sv
module sgn_sar_chk #(
    parameter int MAG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             wr_n,
    input logic             stat_n,
    input logic [MAG_W-1:0] dac_code,
    input logic             swap_pol,
    input logic [MAG_W:0]   result,
    input logic             busy,
    input logic             conv_done,
    input logic             eoc,
    input logic             int_n
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n) && !cs_n && stat_n) |=> (busy && dac_code == '0 && !swap_pol && int_n && !eoc));

    // R10
    status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && !stat_n) |=> (!busy && !eoc && int_n && !conv_done && !swap_pol));

    // R7
    eoc_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> (!busy && dac_code == '0 && !swap_pol));

    // R7
    int_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> ($stable(result) && conv_done));

    // R3
    swap_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pol |-> busy);

    // R6
    busy_eoc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !eoc);
endmodule

bind sgn_sar_seq sgn_sar_chk #(.MAG_W(MAG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .stat_n   (stat_n),
    .dac_code (dac_code),
    .swap_pol (swap_pol),
    .result   (result),
    .busy     (busy),
    .conv_done(conv_done),
    .eoc      (eoc),
    .int_n    (int_n)
);

// File: tb/tb_sgn_sar_seq.sv
`timescale 1ns/1ps
module tb_sgn_sar_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, stat_n = 1'b1;
    logic cmp_hi;
    logic [11:0] dac_code;
    logic swap_pol, samp_b, busy, conv_done, eoc, int_n;
    logic [12:0] result;

    int vin = 0;
    bit force_neg = 1'b0;
    int n_chk = 0, n_fail = 0, e = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sgn_sar_seq dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .stat_n(stat_n),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .swap_pol(swap_pol), .samp_b(samp_b),
        .result(result), .busy(busy), .conv_done(conv_done), .eoc(eoc), .int_n(int_n)
    );

    // Analog model: comparator sees the (possibly swapped) input against the DAC level.
    always_comb begin
        int eff;
        eff = swap_pol ? -vin : vin;
        if (force_neg && dac_code == 12'd0 && !swap_pol) cmp_hi = 1'b0;
        else cmp_hi = (eff >= int'({20'd0, dac_code}));
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_to(input int target);
        repeat (target - e) @(posedge clk);
        @(negedge clk);
        e = target;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        e = 0;
    endtask

    task automatic status_write();
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; stat_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; stat_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !conv_done && !eoc && int_n, "R1 flags", {busy, conv_done, eoc, int_n}, 4'b0001);
        chk(dac_code == 0 && !swap_pol, "R1 dac/swap", {swap_pol, dac_code}, 0);
        chk(result == 0, "R1 result", result, 0);
    endtask

    task automatic run_conv(input int v, input bit fneg);
        logic neg;
        logic [12:0] exp;
        int mag;
        neg = fneg || (v < 0);
        mag = (v < 0) ? -v : v;
        exp = neg ? 13'(-mag) : 13'(mag);
        vin = v; force_neg = fneg;
        pulse_start();
        chk(busy && int_n && !eoc, "R2 started", {busy, int_n, eoc}, 3'b110);
        chk(dac_code == 0 && !swap_pol && !samp_b, "R3 sign step", {swap_pol, samp_b, dac_code}, 0);
        wait_to(3);
        chk(!samp_b, "R5 sample half", samp_b, 0);
        wait_to(4);
        chk(samp_b && dac_code == 0, "R5 compare half", {samp_b, dac_code}, 13'h1000);
        wait_to(8);
        chk(dac_code == 12'h800, "R4 first trial", dac_code, 12'h800);
        chk(swap_pol == neg && !samp_b, "R3 swap", {swap_pol, samp_b}, {neg, 1'b0});
        wait_to(104);
        chk(conv_done && !eoc && busy, "R6 conv_done first", {conv_done, eoc, busy}, 3'b101);
        wait_to(105);
        chk(result == exp, "R8 result latched", result, exp);
        chk(!busy && dac_code == 0 && !swap_pol && !eoc && int_n, "R7 reset before eoc",
            {busy, swap_pol, eoc, int_n}, 4'b0001);
        wait_to(106);
        chk(eoc && !int_n, "R6 eoc/int", {eoc, int_n}, 2'b10);
        chk(result == exp, "R8 result held", result, exp);
        force_neg = 1'b0;
    endtask

    task automatic t_ignore();
        logic [12:0] r0;
        r0 = result;
        @(negedge clk);
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!busy && eoc && !int_n && result == r0, "R2 ignored without cs_n",
            {busy, eoc, int_n}, 3'b010);
    endtask

    task automatic t_restart();
        vin = 300;
        pulse_start();
        repeat (50) @(negedge clk);
        chk(busy && !eoc, "R9 mid first", {busy, eoc}, 2'b10);
        run_conv(-77, 1'b0);
        chk(result == 13'h1FB3, "R9 restart result", result, 13'h1FB3);
    endtask

    task automatic t_abort();
        logic [12:0] r0;
        r0 = result;
        vin = 999;
        pulse_start();
        repeat (40) @(negedge clk);
        status_write();
        chk(!busy && !eoc && int_n && !conv_done && dac_code == 0,
            "R10 abort flags", {busy, eoc, int_n, conv_done}, 4'b0010);
        repeat (150) @(negedge clk);
        chk(!eoc && int_n && result == r0, "R10 no eoc after abort", result, r0);
        run_conv(55, 1'b0);
        status_write();
        chk(!eoc && int_n && !conv_done && result == 13'd55, "R10 clear after done",
            {eoc, int_n, conv_done}, 3'b010);
    endtask

    initial begin
        t_reset();
        run_conv(1234, 1'b0);
        run_conv(-1234, 1'b0);
        run_conv(4095, 1'b0);
        run_conv(-4095, 1'b0);
        run_conv(0, 1'b0);
        run_conv(-1, 1'b0);
        run_conv(0, 1'b1);
        t_ignore();
        t_restart();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule